// File: doc/BRIEF.md
# Dual Card-Image Buffer Manager

This block holds two card images of 80 twelve-bit columns each, for an emulated card reader and punch. The first buffer keeps the card that is waiting to be read. The second keeps the card that is waiting to be punched. Each buffer is a single-port synchronous RAM, and every access to it spends several clock cycles. Each buffer has its own access state machine. An access holds its column address and write data in registers for the whole access, so the strobe sees stable inputs before it and after it.

Five requesters share the two buffers through a request/acknowledge interlock:
- a host that loads a card image into the read buffer;
- the CPU reading from the read buffer;
- the CPU writing into the punch buffer;
- a host that fetches from the punch buffer;
- an internal copy sequencer that moves the read card into the punch buffer.

For each column, the copy does two separate steps. It first finishes a read of the read buffer into a holding register. Only after that read has finished does it start a write of the held value into the punch buffer.

A requester raises its `*_req`, holds its column and data stable, and waits for its one-cycle `*_ack`. It does not step on every clock. A copy is launched by a pulse on `copy_start` and runs without further requests.

Top module: `card_buf_pair`

## Requirements
- R1: After reset, every acknowledge output and `copy_done` are low, and they stay low while no request is raised.
- R2: A column word loaded through the push port at column c (0 to 79) is returned by a later CPU read of column c. `crd_data` is valid in the cycle that `crd_ack` is high.
- R3: A column word written through the CPU write port at column c (0 to 79) is returned by a later fetch of column c. `fetch_data` is valid in the cycle that `fetch_ack` is high.
- R4: Every acknowledge is high for exactly one cycle per access. An access is acknowledged within 10 cycles of its request when no other requester uses the same buffer.
- R5: After a copy completes, every column 0 to 79 of the punch buffer holds the value of the same column of the read buffer. For any column, the copy never uses both buffers at the same time.
- R6: `copy_done` pulses high for exactly one cycle when the last column has been written. A `copy_start` pulse while a copy is running is ignored, so it neither restarts nor lengthens the copy.
- R7: When requests are waiting together, grants follow a fixed order. On the read buffer the order is copy, then CPU read, then push. On the punch buffer the order is copy, then CPU write, then fetch. An access that has been granted always runs to completion.
- R8: Neither buffer machine stalls. Each access returns its machine to idle within ACC+3 cycles of its grant. CPU and host requests raised during a copy are acknowledged before the copy ends.
- R9: An access to a column of 80 or above is still acknowledged. A write there changes no column of the buffer, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Host request to write into the read buffer |
| push_col | input | 7 | Column for the push |
| push_data | input | 12 | Word to push |
| push_ack | output | 1 | Push finished (one cycle) |
| crd_req | input | 1 | CPU request to read the read buffer |
| crd_col | input | 7 | Column for the CPU read |
| crd_data | output | 12 | CPU read word, valid with crd_ack |
| crd_ack | output | 1 | CPU read finished (one cycle) |
| cwr_req | input | 1 | CPU request to write the punch buffer |
| cwr_col | input | 7 | Column for the CPU write |
| cwr_data | input | 12 | Word for the CPU write |
| cwr_ack | output | 1 | CPU write finished (one cycle) |
| fetch_req | input | 1 | Host request to read the punch buffer |
| fetch_col | input | 7 | Column for the fetch |
| fetch_data | output | 12 | Fetched word, valid with fetch_ack |
| fetch_ack | output | 1 | Fetch finished (one cycle) |
| copy_start | input | 1 | Pulse to start a full copy from the read buffer to the punch buffer |
| copy_done | output | 1 | One-cycle pulse when the copy has finished |

## Verification
A buffer machine stuck outside idle shows up as a missing acknowledge. It is visible a few cycles after the access's normal latency, and every later requester of that buffer then starves as well. A wrong owner or a broken priority choice gives an acknowledge to the wrong port, or returns data that is one write older or newer than expected. Both can be seen in the very access where the fault happens. A fault in the copy sequencer shows only after `copy_done`, when the punch buffer is read column by column: a lost or misaligned hold value gives wrong or blank columns, and a restarted copy gives a late `copy_done` pulse.

// File: rtl/card_buf_pair.sv
module card_buf_pair #(
  parameter int COLS = 80,
  parameter int W    = 12,
  parameter int ACC  = 3,
  parameter int AW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW-1:0] push_col,
  input  logic [W-1:0]  push_data,
  output logic          push_ack,
  input  logic          crd_req,
  input  logic [AW-1:0] crd_col,
  output logic [W-1:0]  crd_data,
  output logic          crd_ack,
  input  logic          cwr_req,
  input  logic [AW-1:0] cwr_col,
  input  logic [W-1:0]  cwr_data,
  output logic          cwr_ack,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_col,
  output logic [W-1:0]  fetch_data,
  output logic          fetch_ack,
  input  logic          copy_start,
  output logic          copy_done
);

  localparam int CW = (ACC > 1) ? $clog2(ACC) : 1;
  localparam logic [CW-1:0] CLAST = CW'(ACC - 1);
  localparam logic [AW-1:0] LASTC = AW'(COLS - 1);
  localparam logic [5:0] WE_MAP = 6'b011_100;

  localparam logic [1:0] S_IDLE = 2'd0, S_SET = 2'd1, S_STB = 2'd2, S_DONE = 2'd3;
  localparam logic [1:0] C_IDLE = 2'd0, C_RD = 2'd1, C_WR = 2'd2;

  logic [1:0]    cst;
  logic [AW-1:0] ccol;
  logic [W-1:0]  hold;
  logic          cdone_q;

  logic [2:0]    breq [2];
  logic [AW-1:0] badr [2][3];
  logic [W-1:0]  bwd  [2][3];
  logic [2:0]    back [2];
  logic [W-1:0]  brd  [2];
  logic [1:0]    bcopy;

  assign breq[0]    = {push_req, crd_req, cst == C_RD};
  assign badr[0][0] = ccol;
  assign badr[0][1] = crd_col;
  assign badr[0][2] = push_col;
  assign bwd[0][0]  = '0;
  assign bwd[0][1]  = '0;
  assign bwd[0][2]  = push_data;

  assign breq[1]    = {fetch_req, cwr_req, cst == C_WR};
  assign badr[1][0] = ccol;
  assign badr[1][1] = cwr_col;
  assign badr[1][2] = fetch_col;
  assign bwd[1][0]  = hold;
  assign bwd[1][1]  = cwr_data;
  assign bwd[1][2]  = '0;

  assign push_ack   = back[0][2];
  assign crd_ack    = back[0][1];
  assign crd_data   = brd[0];
  assign cwr_ack    = back[1][1];
  assign fetch_ack  = back[1][2];
  assign fetch_data = brd[1];
  assign copy_done  = cdone_q;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [1:0]    st;
    logic [2:0]    own;
    logic [CW-1:0] cnt;
    logic [AW-1:0] adr;
    logic [W-1:0]  wd;
    logic [W-1:0]  rd;
    logic          we;
    logic [2:0]    pick;
    logic [AW-1:0] sel_adr;
    logic [W-1:0]  sel_wd;
    logic [W-1:0]  mem [COLS];
    logic [7:0]    blen;

    assign pick    = breq[b] & (~breq[b] + 3'd1);
    assign sel_adr = pick[0] ? badr[b][0] : (pick[1] ? badr[b][1] : badr[b][2]);
    assign sel_wd  = pick[0] ? bwd[b][0]  : (pick[1] ? bwd[b][1]  : bwd[b][2]);
    assign back[b] = (st == S_DONE) ? own : 3'b000;
    assign brd[b]  = rd;
    assign bcopy[b] = (st != S_IDLE) && own[0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= S_IDLE;
        own <= '0;
        cnt <= '0;
        adr <= '0;
        wd  <= '0;
        we  <= 1'b0;
        rd  <= '0;
      end else begin
        case (st)
          S_IDLE: if (|breq[b]) begin
            own <= pick;
            adr <= sel_adr;
            wd  <= sel_wd;
            we  <= |(pick & WE_MAP[b*3 +: 3]);
            st  <= S_SET;
          end
          S_SET: begin
            cnt <= '0;
            st  <= S_STB;
          end
          S_STB: if (cnt == CLAST) begin
            st <= S_DONE;
            if (!we) rd <= (adr <= LASTC) ? mem[adr] : '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (st == S_STB && cnt == CLAST && we && adr <= LASTC) mem[adr] <= wd;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || st == S_IDLE) blen <= '0;
      else if (blen != 8'hff) blen <= blen + 8'd1;
    end

    a_r8_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      blen <= 8'(ACC + 2));
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (back[b] != 3'b000) |=> (back[b] == 3'b000));
    a_r7_copy_first: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && breq[b][0]) |=> (own == 3'b001));
    a_r7_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !breq[b][0] && breq[b][1]) |=> (own == 3'b010));
    a_r9_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DONE && !we && adr > LASTC) |-> (rd == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst     <= C_IDLE;
      ccol    <= '0;
      hold    <= '0;
      cdone_q <= 1'b0;
    end else begin
      cdone_q <= 1'b0;
      case (cst)
        C_IDLE: if (copy_start) begin
          ccol <= '0;
          cst  <= C_RD;
        end
        C_RD: if (back[0][0]) begin
          hold <= brd[0];
          cst  <= C_WR;
        end
        C_WR: if (back[1][0]) begin
          if (ccol == LASTC) begin
            cst     <= C_IDLE;
            cdone_q <= 1'b1;
          end else begin
            ccol <= ccol + 1'b1;
            cst  <= C_RD;
          end
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  a_r5_split: assert property (@(posedge clk) disable iff (!rst_n)
    !(bcopy[0] && bcopy[1]));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> !copy_done);

endmodule

// File: tb/card_buf_pair_tb.sv
module card_buf_pair_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 0, crd_req = 0, cwr_req = 0, fetch_req = 0, copy_start = 0;
  logic [6:0] push_col = 0, crd_col = 0, cwr_col = 0, fetch_col = 0;
  logic [11:0] push_data = 0, cwr_data = 0;
  logic [11:0] crd_data, fetch_data;
  logic push_ack, crd_ack, cwr_ack, fetch_ack, copy_done;

  int checks = 0, errors = 0;
  int pr_m [80];
  int pp_m [80];
  int crd_val, fetch_val;
  longint crd_t, push_t, cwr_t, fetch_t;
  int dur_a, dur_b, dur_c;

  always #4 clk = ~clk;

  card_buf_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_col(push_col), .push_data(push_data), .push_ack(push_ack),
    .crd_req(crd_req), .crd_col(crd_col), .crd_data(crd_data), .crd_ack(crd_ack),
    .cwr_req(cwr_req), .cwr_col(cwr_col), .cwr_data(cwr_data), .cwr_ack(cwr_ack),
    .fetch_req(fetch_req), .fetch_col(fetch_col), .fetch_data(fetch_data), .fetch_ack(fetch_ack),
    .copy_start(copy_start), .copy_done(copy_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_push(input int col, input int val);
    int n = 0;
    @(negedge clk);
    push_req = 1; push_col = 7'(col); push_data = 12'(val);
    do begin @(negedge clk); n++; end while (!push_ack && n < 400);
    chk(push_ack, "R4 push ack arrives", n, 0);
    push_t = $time;
    push_req = 0;
    @(negedge clk);
    chk(!push_ack, "R4 push ack one cycle", push_ack, 0);
  endtask

  task automatic do_crd(input int col);
    int n = 0;
    @(negedge clk);
    crd_req = 1; crd_col = 7'(col);
    do begin @(negedge clk); n++; end while (!crd_ack && n < 400);
    chk(crd_ack, "R4 cpu read ack arrives", n, 0);
    crd_val = int'(crd_data);
    crd_t = $time;
    crd_req = 0;
    @(negedge clk);
    chk(!crd_ack, "R4 cpu read ack one cycle", crd_ack, 0);
  endtask

  task automatic do_cwr(input int col, input int val);
    int n = 0;
    @(negedge clk);
    cwr_req = 1; cwr_col = 7'(col); cwr_data = 12'(val);
    do begin @(negedge clk); n++; end while (!cwr_ack && n < 400);
    chk(cwr_ack, "R4 cpu write ack arrives", n, 0);
    cwr_t = $time;
    cwr_req = 0;
    @(negedge clk);
    chk(!cwr_ack, "R4 cpu write ack one cycle", cwr_ack, 0);
  endtask

  task automatic do_fetch(input int col);
    int n = 0;
    @(negedge clk);
    fetch_req = 1; fetch_col = 7'(col);
    do begin @(negedge clk); n++; end while (!fetch_ack && n < 400);
    chk(fetch_ack, "R4 fetch ack arrives", n, 0);
    fetch_val = int'(fetch_data);
    fetch_t = $time;
    fetch_req = 0;
    @(negedge clk);
    chk(!fetch_ack, "R4 fetch ack one cycle", fetch_ack, 0);
  endtask

  task automatic verify_pr(input string tag);
    for (int c = 0; c < 80; c++) begin
      do_crd(c);
      chk(crd_val == pr_m[c], tag, crd_val, pr_m[c]);
    end
  endtask

  task automatic verify_pp(input string tag);
    for (int c = 0; c < 80; c++) begin
      do_fetch(c);
      chk(fetch_val == pp_m[c], tag, fetch_val, pp_m[c]);
    end
  endtask

  task automatic run_copy(input int restart_at, output int dur);
    int n = 1;
    @(negedge clk); copy_start = 1;
    @(negedge clk); copy_start = 0;
    while (!copy_done && n < 20000) begin
      copy_start = (n == restart_at);
      @(negedge clk);
      n++;
    end
    copy_start = 0;
    dur = n;
    chk(copy_done, "R6 copy_done arrives", n, 0);
    @(negedge clk);
    chk(!copy_done, "R6 copy_done one cycle", copy_done, 0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) begin
      @(negedge clk);
      chk({push_ack, crd_ack, cwr_ack, fetch_ack, copy_done} == 5'b0, "R1 idle outputs after reset",
          {push_ack, crd_ack, cwr_ack, fetch_ack, copy_done}, 0);
    end
  endtask

  task automatic t_push_read;
    for (int c = 0; c < 80; c++) begin
      pr_m[c] = (c * 37 + 5) & 12'hfff;
      do_push(c, pr_m[c]);
    end
    verify_pr("R2 push then cpu read");
  endtask

  task automatic t_write_fetch;
    for (int c = 79; c >= 0; c--) begin
      pp_m[c] = (c * 91 + 12'h800) & 12'hfff;
      do_cwr(c, pp_m[c]);
    end
    verify_pp("R3 cpu write then fetch");
  endtask

  task automatic t_out_of_range;
    do_push(90, 12'habc);
    do_cwr(127, 12'h123);
    do_crd(90);
    chk(crd_val == 0, "R9 read beyond last column", crd_val, 0);
    do_fetch(127);
    chk(fetch_val == 0, "R9 fetch beyond last column", fetch_val, 0);
    verify_pr("R9 read buffer untouched");
    verify_pp("R9 punch buffer untouched");
  endtask

  task automatic t_priority;
    int old = pr_m[5];
    fork
      do_crd(5);
      do_push(5, 12'h5a5);
    join
    chk(crd_val == old, "R7 cpu read before push", crd_val, old);
    chk(crd_t < push_t, "R7 cpu read acked first", int'(crd_t), int'(push_t));
    pr_m[5] = 12'h5a5;
    do_crd(5);
    chk(crd_val == pr_m[5], "R7 push done after read", crd_val, pr_m[5]);
    fork
      do_fetch(7);
      do_cwr(7, 12'h3c3);
    join
    chk(fetch_val == 12'h3c3, "R7 cpu write before fetch", fetch_val, 12'h3c3);
    chk(cwr_t < fetch_t, "R7 cpu write acked first", int'(cwr_t), int'(fetch_t));
    pp_m[7] = 12'h3c3;
  endtask

  task automatic t_copy_plain;
    run_copy(-1, dur_a);
    for (int c = 0; c < 80; c++) pp_m[c] = pr_m[c];
    verify_pp("R5 copy result");
  endtask

  task automatic t_copy_restart;
    for (int c = 0; c < 80; c++) begin
      pr_m[c] = (c * 53 + 12'h111) & 12'hfff;
      do_push(c, pr_m[c]);
    end
    run_copy(dur_a / 3, dur_b);
    chk(dur_b == dur_a, "R6 start during copy ignored", dur_b, dur_a);
    for (int c = 0; c < 80; c++) pp_m[c] = pr_m[c];
    verify_pp("R5 copy result after ignored start");
  endtask

  task automatic t_copy_contention;
    bit done_first = 0;
    for (int c = 0; c < 80; c++) begin
      pr_m[c] = (c * 29 + 12'h40) & 12'hfff;
      do_push(c, pr_m[c]);
    end
    fork
      begin run_copy(-1, dur_c); done_first = 1; end
      begin
        for (int k = 0; k < 6; k++) begin
          do_crd(k * 13);
          chk(crd_val == pr_m[k * 13], "R8 cpu read during copy", crd_val, pr_m[k * 13]);
          do_fetch(k * 11);
          chk(!done_first, "R8 fetch served before copy end", done_first, 0);
        end
      end
    join
    for (int c = 0; c < 80; c++) pp_m[c] = pr_m[c];
    verify_pp("R5 copy result with contention");
  endtask

  initial begin
    t_reset;
    t_push_read;
    t_write_fetch;
    t_out_of_range;
    t_priority;
    t_copy_plain;
    t_copy_restart;
    t_copy_contention;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R8 act=%0h exp=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule